// File: doc/BRIEF.md
# Serial ADC Sampling Frame Controller

This block is the master end of a three-wire serial link to a single-channel successive-approximation converter. It makes a serial clock by dividing the system clock. It drives an active-low frame select whose falling edge starts a conversion. It shifts the returned bits in most significant bit first. A sample timer counts whole serial-clock periods between frame starts. Every frame therefore begins on a serial-clock edge, and conversions are evenly spaced in time.

The host chooses the divider, the sample period in serial clocks, and one of two result formats: a 12-bit value that is right-aligned, or a 14-bit value. Each completed full frame delivers a result word with a one-cycle strobe and a quality flag. A power-down request makes the next frame an 8-clock frame. The select line then rises before the conversion completes, which puts the converter to sleep. The next full frame wakes the converter, and its result is marked as not trustworthy.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The serial clock period is 2*(div_cfg+1) system clocks. The serial clock is high whenever cs_n is high.
- R2: A full frame holds cs_n low for exactly 16 serial-clock falling edges. cs_n falls while the serial clock is high. sdata is captured on serial-clock rising edges, and the first bit received is the most significant.
- R3: Frame starts are period_cfg serial-clock periods apart, which is period_cfg*2*(div_cfg+1) system clocks. A period_cfg value below 17 is treated as 17.
- R4: With mode_wide=0, result[11:0] holds the last 12 bits received and result[13:12] is 0. The first four bits received are ignored.
- R5: With mode_wide=1, result[13:0] holds the first 14 bits received. The last two bits received are ignored.
- R6: At the end of each full frame, result_valid is high for exactly one system clock. That clock is the first cycle in which cs_n is high again.
- R7: A one-cycle pd_req makes only the next frame a power-down frame. That frame has 8 serial-clock falling edges and raises no result_valid.
- R8: The first full frame after a power-down frame gives result_ok=0. Every other full frame gives result_ok=1.
- R9: While enable is low, no frame starts, and cs_n and sclk stay high.
- R10: Reset leaves cs_n=1, sclk=1 and result_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Allows frames to start |
| div_cfg | input | 8 | Divider setting; the serial clock half period is div_cfg+1 system clocks |
| period_cfg | input | 10 | Interval between frame starts, in serial clocks (minimum 17) |
| mode_wide | input | 1 | 1: 14-bit result, 0: 12-bit right-aligned result; taken at frame start |
| pd_req | input | 1 | Makes the next frame a power-down frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, idle high |
| result | output | 14 | Last converted value |
| result_valid | output | 1 | One-cycle strobe for result |
| result_ok | output | 1 | 0 when result comes from a wake-up frame |

## Verification
A wrong bit counter shows up in the very frame where it occurs: the number of serial-clock falling edges under a low cs_n changes, and the result word moves by one or more bit positions. A corrupted period counter or divider phase appears within one sample interval as a different spacing between frame starts or between serial clock edges. A wrong power-down flag shows up in the following frame or the one after it, as a frame of the wrong length, a missing or extra result_valid, or a result_ok value that disagrees with the sleep history.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;

  typedef enum logic {
    FS_IDLE   = 1'b0,
    FS_ACTIVE = 1'b1
  } fs_state_t;

endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             term;

  always_comb begin
    term      = (cnt_q >= div_cfg);
    cnt_d     = term ? '0 : cnt_q + 1'b1;
    phase_d   = term ? ~phase_q : phase_q;
    tick_rise = term & ~phase_q;
    tick_fall = term & phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import adc_fc_pkg::*;
#(
  parameter int PER_W      = 10,
  parameter int FRAME_BITS = 16,
  parameter int PD_BITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PER_W-1:0] period_cfg,
  input  logic             mode_wide,
  input  logic             pd_req,
  input  logic             tick_rise,
  input  logic             tick_fall,
  output logic             cs_n,
  output logic             sclk,
  output logic             sample_stb,
  output logic             done_stb,
  output logic             frame_wide,
  output logic             frame_wake
);

  localparam int MIN_PERIOD = FRAME_BITS + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  fs_state_t        state_q, state_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             short_q, short_d;
  logic             wide_q, wide_d;
  logic             wake_q, wake_d;
  logic             asleep_q, asleep_d;
  logic             pend_q, pend_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;

  logic [PER_W-1:0] n_eff;
  logic             per_last;
  logic             start;
  logic             last_bit;

  always_comb begin
    n_eff    = (period_cfg < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : period_cfg;
    per_last = (per_q >= n_eff - 1'b1);
    start    = enable & tick_rise & per_last & (state_q == FS_IDLE);
    last_bit = short_q ? (bit_q == BIT_W'(PD_BITS - 1))
                       : (bit_q == BIT_W'(FRAME_BITS - 1));
    sample_stb = tick_rise & (state_q == FS_ACTIVE);
    done_stb   = sample_stb & last_bit & ~short_q;

    state_d  = state_q;
    bit_d    = bit_q;
    short_d  = short_q;
    wide_d   = wide_q;
    wake_d   = wake_q;
    asleep_d = asleep_q;
    pend_d   = pend_q | pd_req;
    cs_d     = cs_q;

    if (!enable)        per_d = n_eff - 1'b1;
    else if (tick_rise) per_d = per_last ? '0 : per_q + 1'b1;
    else                per_d = per_q;

    case (state_q)
      FS_IDLE: begin
        if (start) begin
          state_d = FS_ACTIVE;
          cs_d    = 1'b0;
          bit_d   = '0;
          short_d = pend_q;
          pend_d  = pd_req;
          wide_d  = mode_wide;
          if (!pend_q) begin
            wake_d   = asleep_q;
            asleep_d = 1'b0;
          end
        end
      end
      FS_ACTIVE: begin
        if (sample_stb) begin
          bit_d = bit_q + 1'b1;
          if (last_bit) begin
            state_d = FS_IDLE;
            cs_d    = 1'b1;
            if (short_q) asleep_d = 1'b1;
          end
        end
      end
      default: state_d = FS_IDLE;
    endcase

    if (cs_d)           sclk_d = 1'b1;
    else if (tick_rise) sclk_d = 1'b1;
    else if (tick_fall) sclk_d = 1'b0;
    else                sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      per_q    <= '0;
      bit_q    <= '0;
      short_q  <= 1'b0;
      wide_q   <= 1'b0;
      wake_q   <= 1'b0;
      asleep_q <= 1'b0;
      pend_q   <= 1'b0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      per_q    <= per_d;
      bit_q    <= bit_d;
      short_q  <= short_d;
      wide_q   <= wide_d;
      wake_q   <= wake_d;
      asleep_q <= asleep_d;
      pend_q   <= pend_d;
      cs_q     <= cs_d;
      sclk_q   <= sclk_d;
    end
  end

  assign cs_n       = cs_q;
  assign sclk       = sclk_q;
  assign frame_wide = wide_q;
  assign frame_wake = wake_q;

endmodule

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int FRAME_BITS  = 16,
  parameter int WIDE_BITS   = 14,
  parameter int NARROW_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic                 done_stb,
  input  logic                 sdata,
  input  logic                 frame_wide,
  input  logic                 frame_wake,
  output logic [WIDE_BITS-1:0] result,
  output logic                 result_valid,
  output logic                 result_ok
);

  localparam logic [FRAME_BITS-1:0] NARROW_MASK =
    {{(FRAME_BITS-NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};
  localparam int WIDE_SHIFT = FRAME_BITS - WIDE_BITS;

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [FRAME_BITS-1:0] word_now;
  logic [WIDE_BITS-1:0]  fmt;
  logic [WIDE_BITS-1:0]  res_q, res_d;
  logic                  vld_q, vld_d;
  logic                  ok_q, ok_d;

  always_comb begin
    word_now = {sh_q[FRAME_BITS-2:0], sdata};
    fmt = frame_wide ? WIDE_BITS'(word_now >> WIDE_SHIFT)
                     : WIDE_BITS'(word_now & NARROW_MASK);
    sh_d  = sample_stb ? word_now : sh_q;
    res_d = done_stb ? fmt : res_q;
    ok_d  = done_stb ? ~frame_wake : ok_q;
    vld_d = done_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      vld_q <= vld_d;
      ok_q  <= ok_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;
  assign result_ok    = ok_q;

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 10,
  parameter int FRAME_BITS  = 16,
  parameter int WIDE_BITS   = 14,
  parameter int NARROW_BITS = 12,
  parameter int PD_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     div_cfg,
  input  logic [PER_W-1:0]     period_cfg,
  input  logic                 mode_wide,
  input  logic                 pd_req,
  input  logic                 sdata,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [WIDE_BITS-1:0] result,
  output logic                 result_valid,
  output logic                 result_ok
);

  logic rst_meta_q, rst_sync_q;
  logic tick_rise, tick_fall;
  logic sample_stb, done_stb;
  logic frame_wide, frame_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sclk_divider #(
    .DIV_W(DIV_W)
  ) div_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .div_cfg  (div_cfg),
    .tick_rise(tick_rise),
    .tick_fall(tick_fall)
  );

  frame_sequencer #(
    .PER_W     (PER_W),
    .FRAME_BITS(FRAME_BITS),
    .PD_BITS   (PD_BITS)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .enable    (enable),
    .period_cfg(period_cfg),
    .mode_wide (mode_wide),
    .pd_req    (pd_req),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sample_stb(sample_stb),
    .done_stb  (done_stb),
    .frame_wide(frame_wide),
    .frame_wake(frame_wake)
  );

  sample_capture #(
    .FRAME_BITS (FRAME_BITS),
    .WIDE_BITS  (WIDE_BITS),
    .NARROW_BITS(NARROW_BITS)
  ) cap_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sample_stb  (sample_stb),
    .done_stb    (done_stb),
    .sdata       (sdata),
    .frame_wide  (frame_wide),
    .frame_wake  (frame_wake),
    .result      (result),
    .result_valid(result_valid),
    .result_ok   (result_ok)
  );

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cs_n,
  input logic sclk,
  input logic result_valid
);

  // R1: serial clock parked high outside a frame
  a_r1_idle_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R2: frame opens while the serial clock is high
  a_r2_start_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);

  // R6: strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6: strobe coincides with the frame closing
  a_r6_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(cs_n));

  // R9: no frame opens while disabled
  a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && cs_n) |=> cs_n);

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .result_valid(result_valid)
);

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [7:0]  div_cfg;
  logic [9:0]  period_cfg;
  logic        mode_wide;
  logic        pd_req;
  logic        sdata;
  logic        cs_n;
  logic        sclk;
  logic [13:0] result;
  logic        result_valid;
  logic        result_ok;

  int n_checks = 0;
  int n_fail   = 0;

  // vector: {mode_wide, adc word, expected result}
  localparam int NVEC = 7;
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 16'h0ABC, 14'h0ABC},
    {1'b0, 16'hF5A3, 14'h05A3},
    {1'b0, 16'h0FFF, 14'h0FFF},
    {1'b1, 16'hFFFC, 14'h3FFF},
    {1'b1, 16'h8003, 14'h2000},
    {1'b1, 16'h5556, 14'h1555},
    {1'b0, 16'h0001, 14'h0001}
  };

  adc_frame_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
    .period_cfg(period_cfg), .mode_wide(mode_wide), .pd_req(pd_req),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .result(result),
    .result_valid(result_valid), .result_ok(result_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // converter model: drives the next bit on each falling serial clock
  logic [15:0] adc_word;
  int          adc_idx;
  always @(negedge cs_n) adc_idx = 15;
  always @(negedge sclk) begin
    if (!cs_n) begin
      sdata <= (adc_idx >= 0) ? adc_word[adc_idx] : 1'b0;
      adc_idx = adc_idx - 1;
    end
  end

  // port monitor, sampled on the falling system clock
  int cyc = 0;
  int cs_fall_cnt = 0, cs_rise_cnt = 0, valid_cnt = 0;
  int falls_in_frame = 0, frame_falls = 0;
  int last_start = 0, start_gap = 0, last_sfall = 0, sclk_gap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !cs_n) begin
      cs_fall_cnt++;
      start_gap = cyc - last_start;
      last_start = cyc;
      falls_in_frame = 0;
    end
    if (prev_sclk && !sclk && !cs_n) begin
      if (falls_in_frame > 0) sclk_gap = cyc - last_sfall;
      last_sfall = cyc;
      falls_in_frame++;
    end
    if (!prev_cs && cs_n) begin
      cs_rise_cnt++;
      frame_falls = falls_in_frame;
    end
    if (result_valid) valid_cnt++;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [13:0] got_res;
  logic        got_ok;
  logic        after_vld;

  task automatic wait_valid();
    do @(negedge clk); while (!result_valid);
    got_res = result;
    got_ok  = result_ok;
    @(negedge clk);
    after_vld = result_valid;
  endtask

  task automatic wait_frame_end();
    int n0 = cs_rise_cnt;
    while (cs_rise_cnt == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v0;
    rst_n = 1'b0; enable = 1'b0; div_cfg = 8'd3; period_cfg = 10'd20;
    mode_wide = 1'b0; pd_req = 1'b0; sdata = 1'b0; adc_word = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 cs_n", cs_n, 1);
    check("R10 sclk", sclk, 1);
    check("R10 result_valid", result_valid, 0);

    // R9: disabled, nothing moves
    repeat (300) @(negedge clk);
    check("R9 no frame while disabled", cs_fall_cnt, 0);
    check("R9 sclk idle", sclk, 1);

    // R2 R4 R5 R6 R8: vector walk
    mode_wide = VEC[0][30];
    adc_word  = VEC[0][29:14];
    enable = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      wait_valid();
      if (i + 1 < NVEC) begin
        mode_wide = VEC[i+1][30];
        adc_word  = VEC[i+1][29:14];
      end
      check(VEC[i][30] ? "R5 wide result" : "R4 narrow result",
            int'(got_res), int'(VEC[i][13:0]));
      check("R8 result_ok", got_ok, 1);
      check("R6 single-cycle valid", after_vld, 0);
      check("R2 falls per full frame", frame_falls, 16);
    end
    // R3 R1: timing at div 3, period 20
    check("R3 start spacing", start_gap, 20 * 8);
    check("R1 sclk period", sclk_gap, 8);

    // R3: clamp to 17
    period_cfg = 10'd5;
    wait_valid();
    wait_valid();
    check("R3 clamped spacing", start_gap, 17 * 8);

    // R1: divider 1
    div_cfg = 8'd1;
    wait_valid();
    wait_valid();
    check("R1 sclk period div1", sclk_gap, 4);
    check("R3 spacing div1", start_gap, 17 * 4);

    // R7 R8: power-down frame, wake frame, normal frame
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    v0 = valid_cnt;
    wait_frame_end();
    check("R7 short frame falls", frame_falls, 8);
    check("R7 no valid for short frame", valid_cnt - v0, 0);
    wait_valid();
    check("R8 wake frame flagged", got_ok, 0);
    check("R7 following frame full", frame_falls, 16);
    wait_valid();
    check("R8 later frame ok", got_ok, 1);
    check("R7 request applied once", frame_falls, 16);

    // R9: disable after a frame
    enable = 1'b0;
    v0 = cs_fall_cnt;
    repeat (400) @(negedge clk);
    check("R9 no frame after disable", cs_fall_cnt - v0, 0);
    check("R9 cs_n high", cs_n, 1);
    check("R9 sclk high", sclk, 1);

    finish_run();
  end

endmodule